// File: doc/BRIEF.md
# Single-Cycle Four-Register Nibble Processor

This block is a small processor core with a 4-bit datapath. It has four general registers and a program store of sixteen 16-bit instruction words. On every rising clock edge it completes one whole instruction. The instruction at the program counter is read combinationally, decoded from its upper byte, executed, and written back. The program counter then moves to its next value on that same edge.

The instruction set has five operations. Two are register-to-register arithmetic: a 4-bit sum and a bitwise NAND. One loads an immediate. One does nothing. One is a conditional relative jump, taken when two registers are equal. A program is loaded through a valid/ready write port that accepts words only while the core is held in synchronous reset. On that port, `ld_ready` is high exactly while `rst` is high, and a word is taken on any rising edge where `ld_valid` and `ld_ready` are both high. There is no other back-pressure. A valid word offered while the core runs is dropped.

A combinational debug port returns any register and the program counter, so a testbench can compare them against its own model.

Top module: `cpu4_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and all four registers become 0. Program store contents are kept.
- R2: `ld_ready` equals `rst`. Word `ld_data` is written to store address `ld_addr` on an edge where `ld_valid` and `ld_ready` are both high. A valid word offered while `rst` is low is discarded and does not change the store.
- R3: Opcode 0x00 (bits [15:8]) writes the 4-bit truncated sum of the sources to the destination, then advances the PC by one. The destination is bits [5:4], source a is bits [3:2] and source b is bits [1:0].
- R4: Opcode 0x01 writes the bitwise inverse of (a AND b) to the destination, using the same fields as R3, then advances the PC by one.
- R5: Opcode 0x02 writes bits [3:0] unchanged into the register chosen by bits [5:4], then advances the PC by one.
- R6: Opcode 0x03 changes no register and advances the PC by one, whatever bits [7:0] hold.
- R7: Opcode 0x04 compares the registers chosen by bits [3:2] and [1:0]. When they are equal, the PC becomes PC plus the two's-complement offset in bits [7:4], modulo 16.
- R8: Opcode 0x04 with unequal compared registers advances the PC by one and writes no register.
- R9: Every opcode from 0x05 to 0xFF behaves as opcode 0x03.
- R10: PC arithmetic wraps modulo 16, so the PC moves from 15 to 0.
- R11: `dbg_reg` shows the register chosen by `dbg_sel` and `dbg_pc` shows the PC, both combinationally.
- R12: When an instruction names its destination as a source, it reads the register's value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| ld_valid | input | 1 | Program word offered |
| ld_ready | output | 1 | Load port accepts a word (high while in reset) |
| ld_addr | input | 4 | Program store address of the offered word |
| ld_data | input | 16 | Offered instruction word |
| dbg_sel | input | 2 | Register index for the debug port |
| dbg_reg | output | 4 | Value of the selected register |
| dbg_pc | output | 4 | Current program counter |

## Verification
The bench sweeps every pair of 4-bit operands through the sum and NAND paths. A truncation or carry-leak fault would show as wrong high-order results, and a swapped field as values landing in the wrong register. It runs every branch offset both taken and not taken. A sign-extension fault sends negative offsets forward, and a fault in the equality test branches when it should not. It tries all 251 undefined opcodes against a register that an accidental write would change. It also runs through the PC wrap and a branch that crosses the wrap. Finally, it offers a load while the core runs; a port that ignored the reset gate would overwrite the program.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;

  // Opcode byte values; dispatch depends on them
  localparam logic [7:0] OPC_SUM  = 8'h00;
  localparam logic [7:0] OPC_NAND = 8'h01;
  localparam logic [7:0] OPC_LDI  = 8'h02;
  localparam logic [7:0] OPC_IDLE = 8'h03;
  localparam logic [7:0] OPC_BEQ  = 8'h04;

  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    RES_SUM  = 2'd0,
    RES_NAND = 2'd1,
    RES_IMM  = 2'd2
  } res_sel_e;

endpackage

// File: rtl/cpu4_progstore.sv
module cpu4_progstore #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // asynchronous read: fetch completes inside the executing cycle
  assign rd_data = mem[rd_addr];

  // R2
  store_write_chk: assert property (@(posedge clk)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/cpu4_decode.sv
module cpu4_decode
  import cpu4_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RSEL_W = 2,
  parameter int DATA_W = 4,
  parameter int PC_W   = 4
) (
  input  logic [WORD_W-1:0] instr,
  output logic              reg_we,
  output res_sel_e          res_sel,
  output logic [RSEL_W-1:0] dst,
  output logic [RSEL_W-1:0] src_a,
  output logic [RSEL_W-1:0] src_b,
  output logic [DATA_W-1:0] imm,
  output logic              is_beq,
  output logic [PC_W-1:0]   offset
);
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int B_LSB   = 0;
  localparam int A_LSB   = RSEL_W;
  localparam int D_LSB   = 2 * RSEL_W;
  localparam int OFF_LSB = 2 * RSEL_W;

  logic [OPC_W-1:0] opc;

  assign opc    = instr[OPC_LSB +: OPC_W];
  assign dst    = instr[D_LSB +: RSEL_W];
  assign src_a  = instr[A_LSB +: RSEL_W];
  assign src_b  = instr[B_LSB +: RSEL_W];
  assign imm    = instr[0 +: DATA_W];
  assign offset = instr[OFF_LSB +: PC_W];

  always_comb begin
    reg_we  = 1'b0;
    res_sel = RES_SUM;
    is_beq  = 1'b0;
    unique case (opc)
      OPC_SUM:  begin reg_we = 1'b1; res_sel = RES_SUM;  end
      OPC_NAND: begin reg_we = 1'b1; res_sel = RES_NAND; end
      OPC_LDI:  begin reg_we = 1'b1; res_sel = RES_IMM;  end
      OPC_BEQ:  is_beq = 1'b1;
      default:  ;  // idle and every unassigned opcode
    endcase
  end

  // R9
  decode_excl_chk: assert final (!(reg_we && is_beq));

endmodule

// File: rtl/cpu4_alu.sv
module cpu4_alu
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm,
  input  res_sel_e          sel,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] nand_v;

  assign sum    = opa + opb;      // carry out discarded
  assign nand_v = ~(opa & opb);

  always_comb begin
    unique case (sel)
      RES_SUM:  result = sum;
      RES_NAND: result = nand_v;
      default:  result = imm;
    endcase
  end

endmodule

// File: rtl/cpu4_regfile.sv
module cpu4_regfile #(
  parameter int NREG   = 4,
  parameter int DATA_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NREG)-1:0] ra_sel,
  input  logic [$clog2(NREG)-1:0] rb_sel,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DATA_W-1:0]       ra,
  output logic [DATA_W-1:0]       rb,
  output logic [DATA_W-1:0]       dbg
);
  localparam int RSEL_W = $clog2(NREG);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                regs[i] <= '0;
      else if (we && waddr == RSEL_W'(i))     regs[i] <= wdata;
    end

    // R8 R9
    hold_unwritten_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && waddr == RSEL_W'(i)) |=> $stable(regs[i]));
  end

  // reads see the value before this edge's write
  assign ra  = regs[ra_sel];
  assign rb  = regs[rb_sel];
  assign dbg = regs[dbg_sel];

  // R12
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int NREG   = 4,
  parameter int PC_W   = 4,
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [PC_W-1:0]         ld_addr,
  input  logic [WORD_W-1:0]       ld_data,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DATA_W-1:0]       dbg_reg,
  output logic [PC_W-1:0]         dbg_pc
);
  localparam int RSEL_W = $clog2(NREG);

  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pc_next;
  logic [WORD_W-1:0] instr;
  logic              reg_we;
  res_sel_e          res_sel;
  logic [RSEL_W-1:0] dst, src_a, src_b;
  logic [DATA_W-1:0] imm;
  logic              is_beq;
  logic [PC_W-1:0]   offset;
  logic [DATA_W-1:0] ra, rb, wb_data;
  logic              take;

  assign ld_ready = rst;

  cpu4_progstore #(.ADDR_W(PC_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (ld_valid && ld_ready),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (pc),
    .rd_data (instr)
  );

  cpu4_decode #(.WORD_W(WORD_W), .RSEL_W(RSEL_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_dec (
    .instr   (instr),
    .reg_we  (reg_we),
    .res_sel (res_sel),
    .dst     (dst),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm     (imm),
    .is_beq  (is_beq),
    .offset  (offset)
  );

  cpu4_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .waddr   (dst),
    .wdata   (wb_data),
    .ra_sel  (src_a),
    .rb_sel  (src_b),
    .dbg_sel (dbg_sel),
    .ra      (ra),
    .rb      (rb),
    .dbg     (dbg_reg)
  );

  cpu4_alu #(.DATA_W(DATA_W)) u_alu (
    .opa    (ra),
    .opb    (rb),
    .imm    (imm),
    .sel    (res_sel),
    .result (wb_data)
  );

  assign take    = is_beq && (ra == rb);
  // offset is two's complement of PC width, so plain modular add applies it
  assign pc_next = take ? pc + offset : pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign dbg_pc = pc;

  // R1
  pc_clear_chk: assert property (@(posedge clk)
    rst |=> pc == '0);

  // R6 R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == PC_W'($past(pc) + 1'b1));

  // R7
  branch_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (is_beq && ra == rb) |=> pc == PC_W'($past(pc) + $past(offset)));

endmodule

// File: tb/sim_cpu4_core.sv
`timescale 1ns/1ps
module sim_cpu4_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [3:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [1:0]  dbg_sel = '0;
  logic [3:0]  dbg_reg;
  logic [3:0]  dbg_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu4_core u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_sel(dbg_sel), .dbg_reg(dbg_reg), .dbg_pc(dbg_pc)
  );

  function automatic logic [15:0] i_sum(int d, int a, int b);
    return {8'h00, 2'b00, 2'(d), 2'(a), 2'(b)};
  endfunction
  function automatic logic [15:0] i_nand(int d, int a, int b);
    return {8'h01, 2'b00, 2'(d), 2'(a), 2'(b)};
  endfunction
  function automatic logic [15:0] i_ldi(int d, int v);
    return {8'h02, 2'b00, 2'(d), 4'(v)};
  endfunction
  function automatic logic [15:0] i_beq(int off, int a, int b);
    return {8'h04, 4'(off), 2'(a), 2'(b)};
  endfunction
  localparam logic [15:0] I_IDLE = 16'h03FF;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int idx, int exp);
    dbg_sel = 2'(idx);
    #1;
    check(req, int'(dbg_reg), exp);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic put(int a, logic [15:0] d);
    rst = 1'b1; ld_valid = 1'b1; ld_addr = 4'(a); ld_data = d;
    @(negedge clk);
  endtask

  task automatic go();
    ld_valid = 1'b0; rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(2);
    // R1 reset state, R2 ready tracks reset
    check("R1 pc", int'(dbg_pc), 0);
    for (int r = 0; r < 4; r++) chk_reg("R1 reg", r, 0);
    check("R2 ready in reset", int'(ld_ready), 1);

    // R10 wrap: fill store with idle words
    for (int a = 0; a < 16; a++) put(a, I_IDLE);
    go();
    for (int i = 1; i <= 17; i++) begin
      run(1);
      check("R10 pc wrap", int'(dbg_pc), i % 16);
    end
    check("R2 ready while running", int'(ld_ready), 0);

    // R7 branch across the wrap: r0==r0 at address 14, offset 3
    put(14, i_beq(3, 0, 0));
    go();
    run(15);
    check("R7 wrap branch", int'(dbg_pc), 1);
    put(14, I_IDLE);

    // R3 R4 R5 sweep of all operand pairs
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        put(0, i_ldi(1, x));
        put(1, i_ldi(2, y));
        put(2, i_sum(0, 1, 2));
        put(3, i_nand(3, 1, 2));
        go();
        run(4);
        check("R3 pc", int'(dbg_pc), 4);
        chk_reg("R3 sum", 0, (x + y) % 16);
        chk_reg("R4 nand", 3, (~(x & y)) & 15);
        chk_reg("R5 imm a", 1, x);
        chk_reg("R5 imm b", 2, y);
      end
    end

    // R12 destination also a source
    put(0, i_ldi(1, 3));
    put(1, i_sum(1, 1, 1));
    put(2, i_nand(2, 1, 1));
    put(3, I_IDLE);
    go();
    run(3);
    chk_reg("R12 self add", 1, 6);
    chk_reg("R12 nand after", 2, 9);

    // R1 reset mid-run
    rst = 1'b1;
    run(1);
    check("R1 pc mid-run", int'(dbg_pc), 0);
    for (int r = 0; r < 4; r++) chk_reg("R1 reg mid-run", r, 0);

    // R11 debug port reads each register
    put(0, i_ldi(0, 1));
    put(1, i_ldi(1, 2));
    put(2, i_ldi(2, 4));
    put(3, i_ldi(3, 8));
    go();
    run(4);
    for (int r = 0; r < 4; r++) chk_reg("R11 dbg", r, 1 << r);
    check("R11 dbg pc", int'(dbg_pc), 4);

    // R7 R8 every offset, taken and not taken
    for (int off = 0; off < 16; off++) begin
      for (int eq = 0; eq < 2; eq++) begin
        put(0, i_ldi(1, 5));
        put(1, i_ldi(2, eq ? 5 : 9));
        put(2, i_beq(off, 1, 2));
        put(3, I_IDLE);
        go();
        run(3);
        if (eq) check("R7 taken pc", int'(dbg_pc), (2 + off) % 16);
        else begin
          check("R8 not taken pc", int'(dbg_pc), 3);
          chk_reg("R8 no write", 1, 5);
          chk_reg("R8 no write b", 2, 9);
        end
      end
    end

    // R6 idle and R9 undefined opcodes, low byte would write r0 if decoded
    for (int op = 3; op < 256; op++) begin
      if (op == 4) continue;
      put(0, i_ldi(1, 5));
      put(1, {8'(op), 8'h04});
      put(2, I_IDLE);
      go();
      run(2);
      check(op == 3 ? "R6 pc" : "R9 pc", int'(dbg_pc), 2);
      chk_reg(op == 3 ? "R6 r0" : "R9 r0", 0, 0);
      chk_reg(op == 3 ? "R6 r1" : "R9 r1", 1, 5);
    end

    // R2 load offered while running is dropped
    put(0, I_IDLE);
    put(1, I_IDLE);
    go();
    run(1);
    ld_valid = 1'b1; ld_addr = 4'd0; ld_data = i_ldi(0, 7);
    #1;
    check("R2 not ready running", int'(ld_ready), 0);
    run(1);
    ld_valid = 1'b0;
    rst = 1'b1;
    run(1);
    go();
    run(1);
    chk_reg("R2 store unchanged", 0, 0);
    check("R2 pc", int'(dbg_pc), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule